// File: doc/BRIEF.md
# Segment Attribute Register Bank

This block stores two attribute flags for each of 256 equal 16 MB slices of a 32-bit address space. One flag marks a slice as cacheable. The other marks it as prefetchable. The 256 slices together cover every address from 0x00000000 through 0xFFFFFFFF.

Software-side logic reaches the bank through a word-wide register port indexed by slice number. Writes take effect at the clock edge. A read returns the full 32-bit entry one cycle after its strobe, through a small two-state response machine.

A second port answers lookups. It takes an address, uses its top byte as the slice number, and returns that slice's two flags combinationally. A cache or prefetch unit can therefore classify an access in the same cycle it is presented. The lowest sixteen slices describe the local internal memory and are fixed at zero, so writes to them have no effect. Every entry clears on reset.

Top module: `mattr_bank`

The read response machine has two states:
- `RD_IDLE`: no response is pending.
- `RD_RESP`: the captured entry is being presented.

Its transitions are:
- `RD_IDLE` goes to `RD_RESP` on a read strobe (*issue*).
- `RD_RESP` stays in `RD_RESP` on another strobe (*chain*).
- `RD_RESP` returns to `RD_IDLE` when there is no strobe (*retire*).

## Requirements
- R1: While `rst_n` is low, every entry clears. After reset, each register read returns 0 and each lookup returns 0 for both flags.
- R2: A write to slice index 16 to 255 loads `wr_data` bit 0 into the cacheable flag and `wr_data` bit 3 into the prefetchable flag. A later read of that index returns the new flags in bit 0 and bit 3.
- R3: Bits of `wr_data` other than 0 and 3 are ignored. Read data always has every bit other than 0 and 3 at zero.
- R4: Writes to slice indices 0 to 15 are discarded. Those entries always read 0, and lookups to them return 0 for both flags.
- R5: When `rd_en` is high at a clock edge, `rd_valid` is high after that edge and `rd_data` carries the entry of `rd_idx`. When `rd_en` is low at an edge, `rd_valid` and `rd_data` are both 0 after it.
- R6: When a read and a write address the same index at the same edge, the read returns the value the entry held before the write.
- R7: The lookup uses `lk_addr[31:24]` as the slice index and ignores `lk_addr[23:0]`. Its outputs follow the address within the same cycle, with no clock edge between.
- R8: A write becomes visible on the lookup port in the cycle right after the write edge.
- R9: A reset applied partway through operation clears all entries written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Slice index for a write |
| wr_data | input | 32 | Write word; only bits 0 and 3 are used |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 8 | Slice index for a read |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 32 | Read response word |
| lk_addr | input | 32 | Lookup address |
| lk_cacheable | output | 1 | Cacheable flag of the addressed slice |
| lk_prefetchable | output | 1 | Prefetchable flag of the addressed slice |

## Verification
Lookup results are due in the cycle their address is applied. The bench therefore drives `lk_addr` at the falling edge and compares the flags one time unit later, before any rising edge.

Read responses are due one rising edge after the strobe. The bench samples `rd_valid` and `rd_data` one time unit after each rising edge and compares them with the reference value taken before that edge's write is applied. This ordering is also what makes the same-index read/write case check the old value.

A write is due on the lookup port from the cycle after its edge. That is the next point at which the bench samples the lookup.

// File: rtl/mattr_pkg.sv
package mattr_pkg;
    localparam int SEG_COUNT  = 256;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int PROT_COUNT = 16;
    localparam int CACHE_POS  = 0;
    localparam int PREF_POS   = 3;
    localparam int IDX_W      = $clog2(SEG_COUNT);

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;
endpackage

// File: rtl/mattr_store.sv
module mattr_store #(
    parameter int SEGS  = 256,
    parameter int PROT  = 16,
    parameter int IDX_W = $clog2(SEGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_cach,
    input  logic             wr_pref,
    output logic [SEGS-1:0]  cach_vec,
    output logic [SEGS-1:0]  pref_vec
);
    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        if (g < PROT) begin : g_fixed
            assign cach_vec[g] = 1'b0;
            assign pref_vec[g] = 1'b0;
        end else begin : g_rw
            logic c_q, p_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c_q <= 1'b0;
                    p_q <= 1'b0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    c_q <= wr_cach;
                    p_q <= wr_pref;
                end
            end
            assign cach_vec[g] = c_q;
            assign pref_vec[g] = p_q;
        end
    end
endmodule

// File: rtl/mattr_lookup.sv
module mattr_lookup #(
    parameter int SEGS   = 256,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(SEGS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEGS-1:0]   cach_vec,
    input  logic [SEGS-1:0]   pref_vec,
    output logic              cacheable,
    output logic              prefetchable
);
    logic [IDX_W-1:0] seg;
    logic             unused_low_addr;

    assign seg             = addr[ADDR_W-1 -: IDX_W];
    assign unused_low_addr = ^addr[ADDR_W-IDX_W-1:0];
    assign cacheable       = cach_vec[seg];
    assign prefetchable    = pref_vec[seg];
endmodule

// File: rtl/mattr_rd_fsm.sv
module mattr_rd_fsm
    import mattr_pkg::*;
#(
    parameter int SEGS   = 256,
    parameter int WORD_W = 32,
    parameter int CPOS   = 0,
    parameter int PPOS   = 3,
    parameter int IDX_W  = $clog2(SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SEGS-1:0]   cach_vec,
    input  logic [SEGS-1:0]   pref_vec,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    rd_state_e         state_q, state_d;
    logic [WORD_W-1:0] entry_w, data_q;

    always_comb begin
        entry_w       = '0;
        entry_w[CPOS] = cach_vec[rd_idx];
        entry_w[PPOS] = pref_vec[rd_idx];
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) data_q <= entry_w;
        end
    end

    always_comb begin
        unique case (state_q)
            RD_RESP: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/mattr_bank.sv
module mattr_bank
    import mattr_pkg::*;
#(
    parameter int SEGS   = SEG_COUNT,
    parameter int PROT   = PROT_COUNT,
    parameter int AW     = ADDR_W,
    parameter int DW     = WORD_W,
    parameter int CPOS   = CACHE_POS,
    parameter int PPOS   = PREF_POS,
    localparam int IW    = $clog2(SEGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_cacheable,
    output logic          lk_prefetchable
);
    logic [SEGS-1:0] cach_vec, pref_vec;
    logic            unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    mattr_store #(.SEGS(SEGS), .PROT(PROT), .IDX_W(IW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_cach  (wr_data[CPOS]),
        .wr_pref  (wr_data[PPOS]),
        .cach_vec (cach_vec),
        .pref_vec (pref_vec)
    );

    mattr_lookup #(.SEGS(SEGS), .ADDR_W(AW), .IDX_W(IW)) u_lookup (
        .addr         (lk_addr),
        .cach_vec     (cach_vec),
        .pref_vec     (pref_vec),
        .cacheable    (lk_cacheable),
        .prefetchable (lk_prefetchable)
    );

    mattr_rd_fsm #(.SEGS(SEGS), .WORD_W(DW), .CPOS(CPOS), .PPOS(PPOS), .IDX_W(IW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .cach_vec (cach_vec),
        .pref_vec (pref_vec),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/mattr_bank_chk.sv
module mattr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [7:0]  rd_idx,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [31:0] lk_addr,
    input logic        lk_cacheable,
    input logic        lk_prefetchable
);
    assert_rd_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == 32'h0));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~32'h9) == 32'h0));

    assert_protected_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx < 8'd16) |=> (rd_data == 32'h0));

    assert_protected_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr[31:24] < 8'd16) |-> (!lk_cacheable && !lk_prefetchable));

    assert_write_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= 8'd16) |=>
            (lk_addr[31:24] != $past(wr_idx) ||
             (lk_cacheable == $past(wr_data[0]) && lk_prefetchable == $past(wr_data[3]))));

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!lk_cacheable && !lk_prefetchable));
endmodule

bind mattr_bank mattr_bank_chk u_chk (.*);

// File: tb/mattr_bank_bench.sv
module mattr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0, lk_addr = '0;
    logic        rd_valid, lk_cacheable, lk_prefetchable;
    logic [31:0] rd_data;

    int  checks = 0, fails = 0;
    bit  m_c[256], m_p[256];
    logic [31:0] exp_rd;
    bit  exp_v;

    always #5 clk = ~clk;

    mattr_bank u_mattr_bank (.*);

    function automatic logic [31:0] mword(int i);
        return {28'h0, m_p[i], 2'b00, m_c[i]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) begin m_c[i] = 0; m_p[i] = 0; end
    endtask

    // One cycle: drive at falling edge, check lookup, clock, check read.
    task automatic step(input bit we, input int widx, input logic [31:0] wd,
                        input bit re, input int ridx, input logic [31:0] addr, input string req);
        int seg;
        @(negedge clk);
        wr_en = we; wr_idx = 8'(widx); wr_data = wd;
        rd_en = re; rd_idx = 8'(ridx); lk_addr = addr;
        #1;
        seg = int'(addr[31:24]);
        chk(lk_cacheable == m_c[seg] && lk_prefetchable == m_p[seg], {req, " lookup"},
            {30'h0, lk_prefetchable, lk_cacheable}, {30'h0, m_p[seg], m_c[seg]});
        @(posedge clk);
        exp_v  = re;
        exp_rd = re ? mword(ridx) : 32'h0;
        if (we && widx >= 16) begin m_c[widx] = wd[0]; m_p[widx] = wd[3]; end
        #1;
        chk(rd_valid == exp_v && rd_data == exp_rd, {req, " read"},
            {rd_valid, rd_data[30:0]}, {exp_v, exp_rd[30:0]});
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: cleared after reset
        step(0, 0, 0, 1, 0,   32'h0000_0000, "R1");
        step(0, 0, 0, 1, 16,  32'h1000_0000, "R1");
        step(0, 0, 0, 1, 255, 32'hFF00_0000, "R1");
        step(0, 0, 0, 0, 0,   32'h8000_0000, "R5");
        // R2, R3: writes keep only bits 0 and 3
        step(1, 16,  32'hFFFF_FFFF, 0, 0,  32'h1000_0000, "R2");
        step(0, 0, 0, 1, 16,  32'h1000_0000, "R3");
        step(1, 255, 32'hFFFF_FFF8, 1, 16, 32'hFF00_0000, "R2");
        step(0, 0, 0, 1, 255, 32'hFF12_3456, "R7");
        step(1, 100, 32'h0000_0001, 0, 0,  32'h64FF_FFFF, "R8");
        step(0, 0, 0, 0, 0,   32'h6400_0000, "R8");
        // R4: protected entries
        step(1, 5,  32'hFFFF_FFFF, 0, 0, 32'h0500_0000, "R4");
        step(1, 15, 32'h0000_0009, 1, 5, 32'h05AB_CDEF, "R4");
        step(0, 0, 0, 1, 15,  32'h0F00_0000, "R4");
        // R6: same-edge read and write
        step(1, 40, 32'h0000_0009, 1, 40, 32'h2800_0000, "R6");
        step(0, 0, 0, 1, 40,  32'h2800_0000, "R6");
        step(1, 40, 32'h0000_0000, 1, 40, 32'h2800_0000, "R6");
        step(0, 0, 0, 0, 40,  32'h2800_0000, "R5");
        // sweep all entries, then read/lookup each
        for (int i = 0; i < 256; i++)
            step(1, i, 32'(i * 32'h3B), 0, 0, {8'(i), 24'h5A5A5A}, "R2");
        for (int i = 0; i < 256; i++)
            step(0, 0, 0, 1, i, {8'(i), 24'(i * 7919)}, "R7");
        // R9: reset mid-run
        @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0;
        model_clear();
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 16; i < 256; i += 17)
            step(0, 0, 0, 1, i, {8'(i), 24'h0}, "R9");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule